// File: doc/BRIEF.md
# SHA-3 Vector Instruction Unit

This unit decodes and executes a small family of fused 128-bit vector instructions used to speed up the Keccak permutation. It holds a 32-entry by 128-bit vector register file. Each instruction word names up to three source registers and one destination register. The unit reads the sources in the issue cycle, computes the result in the following execute cycle, and writes it back at the end of that cycle. Two of the operations treat the vector as full-width bitwise logic. The other two split it into independent 64-bit lanes and rotate within each lane.

Control is a two-state machine. `S_IDLE` accepts a word when `instr_valid` is high; this transition is called ISSUE and moves the unit to `S_EXEC`. `S_EXEC` always returns to `S_IDLE` after one cycle; this transition is called RETIRE, and it performs the writeback when the word was legal. A word that matches none of the four encodings raises `illegal_op` during `S_EXEC` and changes no register. A host port lets software-side test logic load registers while the unit is idle and read any register at any time.

Top module: `kvx_unit`

## Requirements
- R1: After reset, `issue_ready` is 1, `exec_done` and `illegal_op` are 0, and every register reads zero.
- R2: Instruction fields are at fixed positions: destination in bits [4:0], first source in [9:5], third source in [14:10], second source in [20:16], and the rotate amount in [15:10]. The class code is bits [31:21].
- R3: Three-way XOR is class 11'h670 with bit 15 clear. Its result is src1 ^ src2 ^ src3 across all 128 bits.
- R4: Bit-clear-and-XOR is class 11'h671 with bit 15 clear. Its result is src1 ^ (src2 & ~src3) across all 128 bits.
- R5: Rotate-and-XOR is class 11'h673 with bits [15:10] equal to 6'b100011. In each 64-bit lane its result is src1 ^ (src2 rotated left by one).
- R6: XOR-and-rotate is class 11'h674. In each 64-bit lane its result is (src1 ^ src2) rotated right by the amount in bits [15:10]; an amount of zero leaves the XOR unrotated.
- R7: Any other word drives `illegal_op` high in its execute cycle and leaves every register unchanged.
- R8: A word is accepted when `instr_valid` and `issue_ready` are both high. In the next cycle `issue_ready` is 0 and `exec_done` is 1. The cycle after that, `issue_ready` is 1 again and the result is readable on `host_rdata`.
- R9: `instr_valid` is ignored while the unit is in `S_EXEC`. No second instruction executes, and its destination is untouched.
- R10: A host write takes effect only in `S_IDLE`. A host write presented during `S_EXEC` is dropped, because the single write port belongs to the retiring instruction.
- R11: Source operands are captured at ISSUE, so a destination that equals a source produces the result computed from the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word |
| issue_ready | output | 1 | Unit is in S_IDLE and accepts a word |
| exec_done | output | 1 | Unit is in S_EXEC (retiring this cycle) |
| illegal_op | output | 1 | Retiring word matched no encoding |
| host_we | input | 1 | Host register write request |
| host_widx | input | 5 | Host write register index |
| host_wdata | input | VEC_W | Host write data |
| host_ridx | input | 5 | Host read register index |
| host_rdata | output | VEC_W | Register contents at host_ridx |

## Verification
The bench builds the unit at its default width of 128 bits with 64-bit lanes. This configuration gives two independent lanes per vector, so a rotation that leaked across the lane boundary would show up. It also makes every one of the 64 rotate amounts and all 2048 values of the class field affordable to sweep one after another. A second sweep covers all 64 values of bits [15:10] under the rotate-and-XOR class. Expected results come from a bench-side register model that computes each rotation bit by bit.

// File: rtl/kvx_pkg.sv
package kvx_pkg;

    localparam int IDX_W = 5;
    localparam int NREGS = 1 << IDX_W;

    // class codes in bits [31:21]
    localparam logic [10:0] CLS_XOR3 = 11'h670;
    localparam logic [10:0] CLS_BICX = 11'h671;
    localparam logic [10:0] CLS_ROLX = 11'h673;
    localparam logic [10:0] CLS_XROR = 11'h674;
    // fixed tail in bits [15:10] for rotate-and-XOR
    localparam logic [5:0]  ROLX_TAIL = 6'b100011;

    typedef enum logic [2:0] {
        KOP_XOR3,
        KOP_BICX,
        KOP_ROLX,
        KOP_XROR,
        KOP_BAD
    } kop_e;

    typedef struct packed {
        kop_e             op;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rm;
        logic [IDX_W-1:0] ra;
        logic [5:0]       imm;
    } kdec_t;

    typedef enum logic {
        S_IDLE,
        S_EXEC
    } kst_e;

endpackage

// File: rtl/kvx_decode.sv
module kvx_decode
    import kvx_pkg::*;
(
    input  logic [31:0] word,
    output kdec_t       dec
);

    logic [10:0] cls;
    logic [5:0]  tail;

    assign cls  = word[31:21];
    assign tail = word[15:10];

    always_comb begin
        dec.rd  = word[4:0];
        dec.rn  = word[9:5];
        dec.ra  = word[14:10];
        dec.rm  = word[20:16];
        dec.imm = tail;
        dec.op  = KOP_BAD;
        unique case (cls)
            CLS_XOR3: if (!tail[5])          dec.op = KOP_XOR3;
            CLS_BICX: if (!tail[5])          dec.op = KOP_BICX;
            CLS_ROLX: if (tail == ROLX_TAIL) dec.op = KOP_ROLX;
            CLS_XROR:                        dec.op = KOP_XROR;
            default:                         dec.op = KOP_BAD;
        endcase
    end

endmodule

// File: rtl/kvx_regfile.sv
module kvx_regfile #(
    parameter int VEC_W = 128,
    parameter int NREGS = 32,
    parameter int IDX_W = 5,
    parameter int NRD   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           widx,
    input  logic [VEC_W-1:0]           wdata,
    input  logic [NRD-1:0][IDX_W-1:0]  ridx,
    output logic [NRD-1:0][VEC_W-1:0]  rdata
);

    logic [VEC_W-1:0] mem [NREGS];

    for (genvar e = 0; e < NREGS; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[e] <= '0;
            else if (we && widx == IDX_W'(e))
                mem[e] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rport
        assign rdata[p] = mem[ridx[p]];
    end

endmodule

// File: rtl/kvx_datapath.sv
module kvx_datapath
    import kvx_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 64
) (
    input  kop_e                        op,
    input  logic [VEC_W-1:0]            src1,
    input  logic [VEC_W-1:0]            src2,
    input  logic [VEC_W-1:0]            src3,
    input  logic [$clog2(LANE_W)-1:0]   rot,
    output logic [VEC_W-1:0]            result
);

    localparam int LANES = VEC_W / LANE_W;

    logic [VEC_W-1:0] rolx_v;
    logic [VEC_W-1:0] xror_v;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] la, lb, lx;
        assign la = src1[g*LANE_W +: LANE_W];
        assign lb = src2[g*LANE_W +: LANE_W];
        assign lx = la ^ lb;
        assign rolx_v[g*LANE_W +: LANE_W] = la ^ {lb[LANE_W-2:0], lb[LANE_W-1]};
        // shift by LANE_W yields zero, so rot == 0 passes lx through
        assign xror_v[g*LANE_W +: LANE_W] = (lx >> rot) | (lx << (LANE_W - int'(rot)));
    end

    always_comb begin
        unique case (op)
            KOP_XOR3: result = src1 ^ src2 ^ src3;
            KOP_BICX: result = src1 ^ (src2 & ~src3);
            KOP_ROLX: result = rolx_v;
            KOP_XROR: result = xror_v;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/kvx_unit.sv
module kvx_unit
    import kvx_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              issue_ready,
    output logic              exec_done,
    output logic              illegal_op,
    input  logic              host_we,
    input  logic [4:0]        host_widx,
    input  logic [VEC_W-1:0]  host_wdata,
    input  logic [4:0]        host_ridx,
    output logic [VEC_W-1:0]  host_rdata
);

    localparam int SH_W = $clog2(LANE_W);
    localparam int NRD  = 4;

    kst_e st_q, st_d;

    kdec_t dec_w;
    kop_e             op_q;
    logic [IDX_W-1:0] rd_q;
    logic [SH_W-1:0]  rot_q;
    logic [VEC_W-1:0] a_q, b_q, c_q;

    logic [NRD-1:0][IDX_W-1:0] rf_ridx;
    logic [NRD-1:0][VEC_W-1:0] rf_rdata;
    logic                      rf_we;
    logic [IDX_W-1:0]          rf_widx;
    logic [VEC_W-1:0]          rf_wdata;
    logic [VEC_W-1:0]          res;
    logic                      wb_en;
    logic                      issue;

    kvx_decode u_dec (
        .word (instr_word),
        .dec  (dec_w)
    );

    assign rf_ridx[0] = dec_w.rn;
    assign rf_ridx[1] = dec_w.rm;
    assign rf_ridx[2] = dec_w.ra;
    assign rf_ridx[3] = host_ridx;
    assign host_rdata = rf_rdata[3];

    kvx_regfile #(
        .VEC_W (VEC_W),
        .NREGS (NREGS),
        .IDX_W (IDX_W),
        .NRD   (NRD)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .widx  (rf_widx),
        .wdata (rf_wdata),
        .ridx  (rf_ridx),
        .rdata (rf_rdata)
    );

    kvx_datapath #(
        .VEC_W  (VEC_W),
        .LANE_W (LANE_W)
    ) u_dp (
        .op     (op_q),
        .src1   (a_q),
        .src2   (b_q),
        .src3   (c_q),
        .rot    (rot_q),
        .result (res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state: ISSUE and RETIRE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (instr_valid) st_d = S_EXEC;
            S_EXEC: st_d = S_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        issue_ready = 1'b0;
        exec_done   = 1'b0;
        illegal_op  = 1'b0;
        wb_en       = 1'b0;
        unique case (st_q)
            S_IDLE: issue_ready = 1'b1;
            S_EXEC: begin
                exec_done  = 1'b1;
                illegal_op = (op_q == KOP_BAD);
                wb_en      = (op_q != KOP_BAD);
            end
        endcase
    end

    assign issue = instr_valid && issue_ready;

    // operand and control capture at ISSUE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= KOP_BAD;
            rd_q  <= '0;
            rot_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
        end else if (issue) begin
            op_q  <= dec_w.op;
            rd_q  <= dec_w.rd;
            rot_q <= dec_w.imm[SH_W-1:0];
            a_q   <= rf_rdata[0];
            b_q   <= rf_rdata[1];
            c_q   <= rf_rdata[2];
        end
    end

    // single write port: retiring instruction owns it in S_EXEC
    always_comb begin
        if (st_q == S_EXEC) begin
            rf_we    = wb_en;
            rf_widx  = rd_q;
            rf_wdata = res;
        end else begin
            rf_we    = host_we;
            rf_widx  = host_widx;
            rf_wdata = host_wdata;
        end
    end

endmodule

// File: rtl/kvx_unit_chk.sv
module kvx_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_valid,
    input logic issue_ready,
    input logic exec_done,
    input logic illegal_op,
    input logic wb_en
);

    // R8
    issue_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && issue_ready |=> exec_done && !issue_ready);

    // R8
    exec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |=> issue_ready && !exec_done);

    // R7
    illegal_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> exec_done);

    // R7
    illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> !wb_en);

    // R9
    busy_ignores_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_ready && instr_valid |=> issue_ready);

endmodule

bind kvx_unit kvx_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .issue_ready (issue_ready),
    .exec_done   (exec_done),
    .illegal_op  (illegal_op),
    .wb_en       (wb_en)
);

// File: tb/tb_kvx_unit.sv
module tb_kvx_unit;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         instr_valid;
    logic [31:0]  instr_word;
    logic         issue_ready, exec_done, illegal_op;
    logic         host_we;
    logic [4:0]   host_widx, host_ridx;
    logic [127:0] host_wdata, host_rdata;

    int checks = 0;
    int errors = 0;
    logic [127:0] model [32];

    always #4 clk = ~clk;

    kvx_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .issue_ready(issue_ready), .exec_done(exec_done), .illegal_op(illegal_op),
        .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
        .host_ridx(host_ridx), .host_rdata(host_rdata)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input int i, input int salt);
        logic [127:0] v;
        for (int w = 0; w < 4; w++)
            v[w*32 +: 32] = 32'(i * 32'h9E3779B1) ^ 32'(salt * 32'h85EBCA6B)
                          ^ 32'(w * 32'hC2B2AE35) ^ 32'(w + i + 1);
        return v;
    endfunction

    function automatic logic [63:0] rol1(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[i] = x[(i + 63) % 64];
        return y;
    endfunction

    function automatic logic [63:0] rorn(input logic [63:0] x, input int s);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[i] = x[(i + s) % 64];
        return y;
    endfunction

    function automatic logic [31:0] mk(input logic [10:0] cls, input int rm, input logic [5:0] mid,
                                       input int rn, input int rd);
        return {cls, 5'(rm), mid, 5'(rn), 5'(rd)};
    endfunction

    // expected decode and result from R3..R7
    function automatic logic calc(input logic [31:0] w, input logic [127:0] a,
                                  input logic [127:0] b, input logic [127:0] c,
                                  output logic [127:0] r);
        logic [10:0] cls;
        logic [5:0]  f;
        cls = w[31:21];
        f   = w[15:10];
        r   = '0;
        if (cls == 11'h670 && !f[5]) begin
            r = a ^ b ^ c; return 1'b1;
        end
        if (cls == 11'h671 && !f[5]) begin
            r = a ^ (b & ~c); return 1'b1;
        end
        if (cls == 11'h673 && f == 6'b100011) begin
            for (int l = 0; l < 2; l++) r[l*64 +: 64] = a[l*64 +: 64] ^ rol1(b[l*64 +: 64]);
            return 1'b1;
        end
        if (cls == 11'h674) begin
            for (int l = 0; l < 2; l++) r[l*64 +: 64] = rorn(a[l*64 +: 64] ^ b[l*64 +: 64], int'(f));
            return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic load(input int idx, input logic [127:0] v);
        @(negedge clk);
        host_we = 1'b1; host_widx = 5'(idx); host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        model[idx] = v;
    endtask

    task automatic read_chk(input string tag, input int idx);
        host_ridx = 5'(idx);
        #1;
        chk(tag, host_rdata, model[idx]);
    endtask

    task automatic run(input logic [31:0] w, input string tag);
        logic [127:0] e;
        logic ok;
        int d;
        d  = int'(w[4:0]);
        ok = calc(w, model[w[9:5]], model[w[20:16]], model[w[14:10]], e);
        @(negedge clk);
        chk("R8 ready before issue", 128'(issue_ready), 128'(1));
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R8 done in exec", 128'(exec_done), 128'(1));
        chk("R8 busy in exec", 128'(issue_ready), 128'(0));
        chk({tag, " R7 illegal flag"}, 128'(illegal_op), 128'(!ok));
        @(negedge clk);
        if (ok) model[d] = e;
        read_chk(tag, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] e;
        logic ok;
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
        host_we = 1'b0; host_widx = '0; host_wdata = '0; host_ridx = '0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ready", 128'(issue_ready), 128'(1));
        chk("R1 done", 128'(exec_done), 128'(0));
        chk("R1 illegal", 128'(illegal_op), 128'(0));
        for (int i = 0; i < 32; i++) read_chk("R1 register zero", i);

        // R10 host loads while idle
        for (int i = 0; i < 32; i++) load(i, pat(i, 1));
        for (int i = 0; i < 32; i++) read_chk("R10 host load", i);

        // R3 with R2 field positions
        for (int k = 0; k < 32; k++)
            run(mk(11'h670, (k + 9) % 32, {1'b0, 5'((k * 5 + 1) % 32)}, k, (k * 7 + 3) % 32), "R3 R2");
        // R4
        for (int k = 0; k < 32; k++)
            run(mk(11'h671, (k + 11) % 32, {1'b0, 5'((k * 3 + 2) % 32)}, (k + 4) % 32, (k * 5 + 7) % 32), "R4 R2");
        // R5
        for (int k = 0; k < 32; k++)
            run(mk(11'h673, (k + 17) % 32, 6'b100011, (k * 3) % 32, (k * 11 + 1) % 32), "R5");
        // R6 every rotate amount, including zero
        for (int k = 0; k < 64; k++)
            run(mk(11'h674, (k + 5) % 32, 6'(k), (k * 7 + 2) % 32, (k * 13 + 9) % 32), "R6");

        // R11 destination equals sources
        load(5, pat(5, 9));
        run(mk(11'h673, 5, 6'b100011, 5, 5), "R11");
        load(6, pat(6, 9));
        run(mk(11'h674, 6, 6'd17, 6, 6), "R11");

        // R7 sweep every class code
        for (int c = 0; c < 2048; c++)
            run(mk(11'(c), c % 32, 6'(c * 11), (c * 3) % 32, (c + 17) % 32), "R7");
        // R7 and R5: every tail under the rotate-and-XOR class
        for (int t = 0; t < 64; t++)
            run(mk(11'h673, (t + 1) % 32, 6'(t), (t + 2) % 32, (t * 3 + 4) % 32), "R7 R5 tail");

        // R9 and R10: valid and host write during S_EXEC
        load(7, pat(7, 3));
        ok = calc(mk(11'h670, 3, 6'd4, 2, 1), model[2], model[3], model[4], e);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = mk(11'h670, 3, 6'd4, 2, 1);
        @(negedge clk);
        instr_word = mk(11'h670, 8, 6'd9, 10, 6);
        host_we = 1'b1; host_widx = 5'd7; host_wdata = ~model[7];
        @(negedge clk);
        instr_valid = 1'b0; host_we = 1'b0;
        if (ok) model[1] = e;
        #1;
        chk("R9 ready after retire", 128'(issue_ready), 128'(1));
        chk("R9 no second exec", 128'(exec_done), 128'(0));
        read_chk("R9 first result", 1);
        read_chk("R9 ignored destination", 6);
        read_chk("R10 host write dropped", 7);
        @(negedge clk);
        chk("R9 still idle", 128'(exec_done), 128'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule